// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core and turns them into one vectored request at an instruction boundary. There are five sources, numbered 0 to 4 in poll order: external line 0, timer 0 overflow, external line 1, timer 1 overflow and the serial port. The serial source requests while either of its two flags is set: a transmit-done flag or a receive-done flag. Timer and serial flags are set by one-cycle pulses from blocks outside this one. The external lines are active-low pins. They are synchronized in this block and can be treated as either level or falling-edge requests.

Software writes a mask register and a level register. The core sees `irq_req` and `vector`, and it answers with `irq_ack` when it jumps to the handler and with `reti` when the handler returns. Two in-service flags track nesting. A high-level handler can interrupt a low-level one, and nothing can interrupt a high-level handler. The controller clears the flag that raised the request when the request is accepted, except for the serial flags, which stay set until software clears them.

Top module: `intc_two_level`

## Requirements
- R1: After reset `irq_req` is 0 and `vector` is 0x0000, all mask, level and type bits are 0, and no flag is pending.
- R2: A source can request only when its own mask bit and the global bit are both 1. In the mask word the global bit is bit 7, and source n uses bit n. Bits 5 and 6 have no effect.
- R3: When requests of both levels are eligible, the one whose level bit is 1 (high) is presented, whatever its poll position. Level bit n belongs to source n.
- R4: Among eligible requests of the same level, the source with the lowest number is presented.
- R5: `vector` equals 0x0003 + 8·n for the presented source n (0x0003, 0x000B, 0x0013, 0x001B, 0x0023), and it is 0x0000 whenever `irq_req` is 0.
- R6: With a low-level handler in service, only high-level requests are presented. With a high-level handler in service, nothing is presented. With nothing in service, any eligible request is presented.
- R7: A `reti` pulse clears the high in-service flag if it is set, and otherwise clears the low one.
- R8: Acceptance (`irq_ack` while `irq_req` is 1) clears the flag of a timer source or of an edge-mode external source. It does not clear either serial flag. A serial flag is cleared by `ser_clr_we`, where `ser_clr_sel` bit 0 selects the receive flag and bit 1 selects the transmit flag.
- R9: The serial source requests while its receive flag is set, while its transmit flag is set, or while both are set.
- R10: With type bit g = 1, a falling edge on the synchronized `ext_pin_n[g]` latches a flag that stays set after the pin rises. With type bit g = 0, the request follows the low level of the pin.
- R11: `irq_req` is 1 only while `instr_boundary` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ext_pin_n | input | 2 | Active-low external request pins, index g = external g |
| tmr_ovf | input | 2 | One-cycle overflow pulses from timer 0 (bit 0) and timer 1 (bit 1) |
| ser_tx_done | input | 1 | One-cycle pulse that sets the serial transmit flag |
| ser_rx_done | input | 1 | One-cycle pulse that sets the serial receive flag |
| ser_clr_we | input | 1 | Software clear strobe for the serial flags |
| ser_clr_sel | input | 2 | Flags to clear: bit 0 receive, bit 1 transmit |
| en_we | input | 1 | Write strobe for the mask register |
| en_wdata | input | 8 | Mask value: bit 7 global, bits 4..0 per source |
| pri_we | input | 1 | Write strobe for the level register |
| pri_wdata | input | 8 | Level value: bits 4..0, 1 = high |
| type_we | input | 1 | Write strobe for the external type bits |
| type_wdata | input | 2 | 1 = falling-edge latched, 0 = low level |
| instr_boundary | input | 1 | Core is between instructions |
| irq_ack | input | 1 | Core takes the presented interrupt |
| reti | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | Interrupt presented to the core |
| vector | output | 16 | Handler address of the presented source |

## Verification
The arbitration is tested with several mixes of pending flags. Three low-level timer and serial flags pending together show whether the poll order is kept. A low-numbered low-level source against a high-numbered high-level source shows whether level takes precedence over poll position. In one sequence, software enables and disables sources, the core accepts and returns, and new requests arrive during both a low-level and a high-level handler. This separates correct preemption from preemption that is wrongly allowed or wrongly blocked. The same sequence shows which in-service flag each `reti` clears, and it checks that the serial request stays pending after acceptance. Both external modes are driven with a short low pulse. In edge mode the request must stay after the pin rises, and in level mode it must drop.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC       = 5;
  localparam int NEXT       = 2;
  localparam int NTMR       = 2;
  localparam int IDX_W      = $clog2(NSRC);
  localparam int GLOBAL_BIT = 7;
  localparam int SER_IDX    = NSRC - 1;
  localparam logic [15:0] VEC_BASE  = 16'h0003;
  localparam int          VEC_SHIFT = 3;

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;
endpackage

// File: rtl/intc_ext_line.sv
module intc_ext_line #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   flag_q, flag_d;
  logic                   pin_s, fall;

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~pin_s;

  always_comb begin
    flag_d = flag_q;
    if (edge_mode && fall) flag_d = 1'b1;
    else if (clr)          flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= pin_s;
      flag_q <= flag_d;
    end
  end

  assign req = edge_mode ? flag_q : ~pin_s;

  // Edge-mode latch holds after the pin goes back high
  assert_edge_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && flag_q && !clr && $stable(edge_mode)) |=> flag_q);
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter import intc_pkg::*; #(
  parameter int N = NSRC
) (
  input  logic [N-1:0]        cand,
  input  logic [N-1:0]        level_hi,
  input  logic                hi_busy,
  input  logic                lo_busy,
  output logic [N-1:0]        grant,
  output logic [$clog2(N)-1:0] grant_idx,
  output logic                grant_hi,
  output logic                any
);
  logic [N-1:0] hi_c, lo_c, pick;

  always_comb begin
    hi_c      = cand & level_hi & {N{~hi_busy}};
    lo_c      = cand & ~level_hi & {N{~hi_busy & ~lo_busy}};
    grant_hi  = |hi_c;
    pick      = grant_hi ? hi_c : lo_c;
    any       = |pick;
    grant     = '0;
    grant_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pick[i]) grant_idx = i[$clog2(N)-1:0];
    end
    if (any) grant[grant_idx] = 1'b1;
  end
endmodule

// File: rtl/intc_nest.sv
module intc_nest (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic hi_act,
  output logic lo_act
);
  logic hi_d, lo_d;

  always_comb begin
    hi_d = hi_act;
    lo_d = lo_act;
    if (take) begin
      if (take_hi) hi_d = 1'b1;
      else         lo_d = 1'b1;
    end else if (reti) begin
      if (hi_act) hi_d = 1'b0;
      else        lo_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_act <= 1'b0;
      lo_act <= 1'b0;
    end else begin
      hi_act <= hi_d;
      lo_act <= lo_d;
    end
  end

  // Return pops the high level first and leaves the low level alone
  assert_reti_pops_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && hi_act) |=> (!hi_act && $stable(lo_act)));
  assert_reti_pops_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && !hi_act) |=> !lo_act);
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level import intc_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  ext_pin_n,
  input  logic [1:0]  tmr_ovf,
  input  logic        ser_tx_done,
  input  logic        ser_rx_done,
  input  logic        ser_clr_we,
  input  logic [1:0]  ser_clr_sel,
  input  logic        en_we,
  input  logic [7:0]  en_wdata,
  input  logic        pri_we,
  input  logic [7:0]  pri_wdata,
  input  logic        type_we,
  input  logic [1:0]  type_wdata,
  input  logic        instr_boundary,
  input  logic        irq_ack,
  input  logic        reti,
  output logic        irq_req,
  output logic [15:0] vector
);
  logic [1:0]      rst_pipe;
  logic            rst_q;
  logic [NSRC-1:0] en_src_q, en_src_d, pri_q, pri_d;
  logic            en_all_q, en_all_d;
  logic [NEXT-1:0] type_q, type_d, ext_req;
  logic [NTMR-1:0] tmr_q, tmr_d;
  logic            ser_rx_q, ser_rx_d, ser_tx_q, ser_tx_d;
  logic [NSRC-1:0] pending, cand, grant;
  logic [IDX_W-1:0] grant_idx;
  logic            grant_hi, any, accept, hi_act, lo_act;

  // Reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  assign accept = irq_ack & irq_req;

  always_comb begin
    en_src_d = en_src_q;
    en_all_d = en_all_q;
    pri_d    = pri_q;
    type_d   = type_q;
    if (en_we) begin
      en_src_d = en_wdata[NSRC-1:0];
      en_all_d = en_wdata[GLOBAL_BIT];
    end
    if (pri_we)  pri_d  = pri_wdata[NSRC-1:0];
    if (type_we) type_d = type_wdata;
    for (int t = 0; t < NTMR; t++) begin
      if (tmr_ovf[t])                   tmr_d[t] = 1'b1;
      else if (accept && grant[2*t+1])  tmr_d[t] = 1'b0;
      else                              tmr_d[t] = tmr_q[t];
    end
    ser_rx_d = ser_rx_q;
    ser_tx_d = ser_tx_q;
    if (ser_rx_done)                      ser_rx_d = 1'b1;
    else if (ser_clr_we && ser_clr_sel[0]) ser_rx_d = 1'b0;
    if (ser_tx_done)                      ser_tx_d = 1'b1;
    else if (ser_clr_we && ser_clr_sel[1]) ser_tx_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      en_src_q <= '0;
      en_all_q <= 1'b0;
      pri_q    <= '0;
      type_q   <= '0;
      tmr_q    <= '0;
      ser_rx_q <= 1'b0;
      ser_tx_q <= 1'b0;
    end else begin
      en_src_q <= en_src_d;
      en_all_q <= en_all_d;
      pri_q    <= pri_d;
      type_q   <= type_d;
      tmr_q    <= tmr_d;
      ser_rx_q <= ser_rx_d;
      ser_tx_q <= ser_tx_d;
    end
  end

  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    intc_ext_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk       (clk),
      .rst_n     (rst_q),
      .pin_n     (ext_pin_n[g]),
      .edge_mode (type_q[g]),
      .clr       (accept & grant[2*g]),
      .req       (ext_req[g])
    );
  end

  always_comb begin
    for (int s = 0; s < NEXT; s++) pending[2*s]   = ext_req[s];
    for (int s = 0; s < NTMR; s++) pending[2*s+1] = tmr_q[s];
    pending[SER_IDX] = ser_rx_q | ser_tx_q;
    cand = pending & en_src_q & {NSRC{en_all_q}};
  end

  intc_arbiter #(.N(NSRC)) u_arb (
    .cand      (cand),
    .level_hi  (pri_q),
    .hi_busy   (hi_act),
    .lo_busy   (lo_act),
    .grant     (grant),
    .grant_idx (grant_idx),
    .grant_hi  (grant_hi),
    .any       (any)
  );

  intc_nest u_nest (
    .clk     (clk),
    .rst_n   (rst_q),
    .take    (accept),
    .take_hi (grant_hi),
    .reti    (reti),
    .hi_act  (hi_act),
    .lo_act  (lo_act)
  );

  assign irq_req = instr_boundary & any;
  assign vector  = irq_req ? (VEC_BASE + (16'(grant_idx) << VEC_SHIFT)) : 16'h0000;

  assert_vector_slot_R5: assert property (@(posedge clk) disable iff (!rst_q)
    irq_req |-> (vector[2:0] == 3'b011 && vector[15:6] == 10'd0));
  assert_high_not_preempted_R6: assert property (@(posedge clk) disable iff (!rst_q)
    hi_act |-> !irq_req);
  assert_timer_flag_cleared_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && grant[SRC_TMR0] && !tmr_ovf[0]) |=> !tmr_q[0]);
  assert_serial_kept_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (accept && grant[SRC_SER] && ser_rx_q && !ser_clr_we) |=> ser_rx_q);
  assert_gated_by_global_R2: assert property (@(posedge clk) disable iff (!rst_q)
    !en_all_q |-> !irq_req);
endmodule

// File: tb/tb_intc_two_level.sv
module tb_intc_two_level;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_pin_n = 2'b11;
  logic [1:0]  tmr_ovf = '0;
  logic        ser_tx_done = 1'b0, ser_rx_done = 1'b0;
  logic        ser_clr_we = 1'b0;
  logic [1:0]  ser_clr_sel = '0;
  logic        en_we = 1'b0, pri_we = 1'b0, type_we = 1'b0;
  logic [7:0]  en_wdata = '0, pri_wdata = '0;
  logic [1:0]  type_wdata = '0;
  logic        instr_boundary = 1'b1, irq_ack = 1'b0, reti = 1'b0;
  logic        irq_req;
  logic [15:0] vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intc_two_level dut (
    .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .tmr_ovf(tmr_ovf),
    .ser_tx_done(ser_tx_done), .ser_rx_done(ser_rx_done),
    .ser_clr_we(ser_clr_we), .ser_clr_sel(ser_clr_sel),
    .en_we(en_we), .en_wdata(en_wdata), .pri_we(pri_we), .pri_wdata(pri_wdata),
    .type_we(type_we), .type_wdata(type_wdata),
    .instr_boundary(instr_boundary), .irq_ack(irq_ack), .reti(reti),
    .irq_req(irq_req), .vector(vector)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Checks the request flag and the vector together, as one value
  task automatic expect_irq(string tag, logic exp_req, logic [15:0] exp_vec);
    checks++;
    if (irq_req !== exp_req || vector !== exp_vec) begin
      errors++;
      $display("FAIL %s: req=%b vector=%h expected req=%b vector=%h",
               tag, irq_req, vector, exp_req, exp_vec);
    end
  endtask

  task automatic wr_en(logic [7:0] v);
    en_wdata = v; en_we = 1'b1; tick(); en_we = 1'b0;
  endtask
  task automatic wr_pri(logic [7:0] v);
    pri_wdata = v; pri_we = 1'b1; tick(); pri_we = 1'b0;
  endtask
  task automatic wr_type(logic [1:0] v);
    type_wdata = v; type_we = 1'b1; tick(); type_we = 1'b0;
  endtask
  task automatic pulse_tmr(logic [1:0] m);
    tmr_ovf = m; tick(); tmr_ovf = '0;
  endtask
  task automatic do_ack();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask
  task automatic do_reti();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask
  task automatic clr_ser(logic [1:0] sel);
    ser_clr_sel = sel; ser_clr_we = 1'b1; tick(); ser_clr_we = 1'b0;
  endtask

  task automatic t_reset();
    expect_irq("R1 reset outputs", 1'b0, 16'h0000);
    pulse_tmr(2'b01);
    wr_en(8'h80);
    expect_irq("R1 mask bits cleared by reset", 1'b0, 16'h0000);
    wr_en(8'h82);
    expect_irq("R1 timer0 pending after set", 1'b1, 16'h000B);
    do_ack();
    do_reti();
    wr_en(8'h00);
  endtask

  task automatic t_enable();
    pulse_tmr(2'b01);
    wr_en(8'h02);
    expect_irq("R2 source bit without global", 1'b0, 16'h0000);
    wr_en(8'h80);
    expect_irq("R2 global without source bit", 1'b0, 16'h0000);
    wr_en(8'hE0);
    expect_irq("R2 bits 6,5 have no effect", 1'b0, 16'h0000);
    wr_en(8'h82);
    expect_irq("R5 timer0 vector", 1'b1, 16'h000B);
    do_ack();
    expect_irq("R6 low in service blocks nothing else pending", 1'b0, 16'h0000);
    do_reti();
    expect_irq("R8 timer0 flag cleared on accept", 1'b0, 16'h0000);
    wr_en(8'h00);
  endtask

  task automatic t_order();
    wr_pri(8'h00);
    tmr_ovf = 2'b11; ser_rx_done = 1'b1; tick(); tmr_ovf = '0; ser_rx_done = 1'b0;
    wr_en(8'h9F);
    expect_irq("R4 timer0 before timer1 and serial", 1'b1, 16'h000B);
    do_ack();
    expect_irq("R6 low does not preempt low", 1'b0, 16'h0000);
    do_reti();
    expect_irq("R4 timer1 next, R5 vector", 1'b1, 16'h001B);
    do_ack(); do_reti();
    expect_irq("R9 serial via receive flag", 1'b1, 16'h0023);
    do_ack(); do_reti();
    expect_irq("R8 serial flag survives accept", 1'b1, 16'h0023);
    clr_ser(2'b01);
    expect_irq("R8 software clear of receive flag", 1'b0, 16'h0000);
    ser_tx_done = 1'b1; tick(); ser_tx_done = 1'b0;
    expect_irq("R9 serial via transmit flag", 1'b1, 16'h0023);
    clr_ser(2'b01);
    expect_irq("R8 clear of receive leaves transmit", 1'b1, 16'h0023);
    clr_ser(2'b10);
    expect_irq("R8 software clear of transmit flag", 1'b0, 16'h0000);
    wr_en(8'h00);
  endtask

  task automatic t_priority();
    wr_pri(8'h08);
    pulse_tmr(2'b11);
    wr_en(8'h8A);
    expect_irq("R3 high timer1 beats low timer0", 1'b1, 16'h001B);
    do_ack();
    expect_irq("R6 high in service not preempted", 1'b0, 16'h0000);
    do_reti();
    expect_irq("R6 low pending after high returns", 1'b1, 16'h000B);
    do_ack();
    pulse_tmr(2'b10);
    expect_irq("R6 high preempts low in service", 1'b1, 16'h001B);
    do_ack();
    do_reti();
    pulse_tmr(2'b01);
    expect_irq("R7 first return left low in service", 1'b0, 16'h0000);
    do_reti();
    expect_irq("R7 second return frees low level", 1'b1, 16'h000B);
    instr_boundary = 1'b0;
    tick();
    expect_irq("R11 no request between boundaries", 1'b0, 16'h0000);
    instr_boundary = 1'b1;
    tick();
    do_ack(); do_reti();
    wr_en(8'h00); wr_pri(8'h00);
  endtask

  task automatic t_external();
    wr_type(2'b10);
    wr_en(8'h85);
    ext_pin_n[1] = 1'b0; tick(); ext_pin_n[1] = 1'b1;
    tick(4);
    expect_irq("R10 edge mode latches after pin rises", 1'b1, 16'h0013);
    do_ack(); do_reti();
    expect_irq("R8 edge flag cleared on accept", 1'b0, 16'h0000);
    ext_pin_n[0] = 1'b0;
    tick(3);
    expect_irq("R10 level mode follows low pin, R5", 1'b1, 16'h0003);
    ext_pin_n[0] = 1'b1;
    tick(3);
    expect_irq("R10 level mode drops with pin", 1'b0, 16'h0000);
    wr_en(8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_enable();
    t_order();
    t_priority();
    t_external();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule